// File: doc/BRIEF.md
# Configuration Port Command Sequencer

This block sits between a simple register-access request interface and the internal configuration access port of a programmable device. The host presents a register address, and raises either a write strobe (with a 32-bit data word) or a read strobe. The sequencer then plays out, one word per clock, the exact stream the port expects. A write runs sync, padding no-ops, a single-word write packet, a desync command and closing padding. A read runs sync, padding, a single-word read packet, a chip-select and direction turnaround, a read window, and then the same desync tail.

Each packet header is built from a fixed type-one layout. Bits 31:29 hold 001. Bits 28:27 hold the opcode (01 for read, 10 for write). Bits 26:13 hold the register index, zero-extended from the host address. Bits 10:0 hold a word count of one, and bits 12:11 are zero. A device reload is simply a write of command value 0x0000000F to the command register at index 4. The word captured from the port on the last read-window cycle is kept in a result register for the host. A one-cycle done pulse marks the end of every sequence.

Top module: `cfg_cmd_sequencer`

## Requirements
- R1: After reset and whenever no sequence runs, portCsN is 1, portRdWrN is 0, portDin is the no-op word 0x20000000, done is 0, and rdData starts at 0.
- R2: Every accepted request first emits 0xAA995566 and then two 0x20000000 words, all with portCsN=0 and portRdWrN=0, starting in the cycle after the request is sampled.
- R3: A write then emits its header (opcode 10, for example 0x30008001 for index 4), then the latched data word, then two no-op words.
- R4: Every sequence ends with 0x30008001, then 0x0000000D, then two no-op words, all with portCsN=0 and portRdWrN=0. A write is 11 words long in total.
- R5: A read emits, after the sync and padding, its header (opcode 01, for example 0x2802C001 for index 0x16), then two no-op words.
- R6: After that padding, a read drives one no-op cycle with portCsN=1 and portRdWrN=1. It then drives four no-op cycles with portCsN=0 and portRdWrN=1, before the tail of R4. A read is 15 words long in total.
- R7: rdData takes the value on portDout at the end of the last of the four read-window cycles, and keeps it until the next read. Writes leave it unchanged.
- R8: done is high for exactly one cycle: the cycle right after the final word. In that cycle the port outputs are already in the idle state of R1.
- R9: Requests are ignored while a sequence runs and in the done cycle. Address and data are latched when the request is accepted, so later changes to them have no effect on the running stream.
- R10: If wrReq and rdReq are both high when a request is accepted, a write sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register index of the request |
| wrData | input | 32 | Data word for a write request |
| wrReq | input | 1 | Write request strobe |
| rdReq | input | 1 | Read request strobe |
| done | output | 1 | One-cycle end-of-sequence pulse |
| rdData | output | 32 | Result captured by the last read |
| portCsN | output | 1 | Port chip select, active low |
| portRdWrN | output | 1 | Port direction, 1 = read |
| portDin | output | 32 | Word driven into the port |
| portDout | input | 32 | Word returned by the port |

## Verification
The bench changes portDout to a fresh random value every cycle. A capture taken one cycle early or late therefore leaves a wrong value in rdData. The request strobes stay high through the done cycle and beyond, so a design that restarts would show a second sync word. Address and data are scrambled while a sequence runs, which exposes a header built from live inputs instead of latched ones. Simultaneous strobes, the reload command and data words equal to the sync or desync codes are driven on purpose, so that wrong priority or a mis-counted turnaround shows up as a word or direction mismatch.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;

  localparam int REG_FIELD_W = 14;
  localparam int CNT_W       = 11;

  localparam logic [31:0] SYNC_WORD  = 32'hAA995566;
  localparam logic [31:0] NOP_WORD   = 32'h20000000;
  localparam logic [31:0] DESYNC_CMD = 32'h0000000D;

  localparam logic [REG_FIELD_W-1:0] CMD_REG = REG_FIELD_W'(4);
  localparam logic [1:0] OP_RD = 2'b01;
  localparam logic [1:0] OP_WR = 2'b10;

  typedef enum logic [2:0] {
    SEL_NOP,
    SEL_SYNC,
    SEL_HDR,
    SEL_DATA,
    SEL_CMDHDR,
    SEL_DESYNC
  } wordSelT;

  // strobes from control to datapath
  typedef struct packed {
    logic    load;
    logic    capture;
    logic    rdOp;
    logic    csN;
    logic    rdWrN;
    wordSelT sel;
  } ctrlT;

  function automatic logic [31:0] makeHeader(input logic [1:0] op,
                                             input logic [REG_FIELD_W-1:0] regIdx,
                                             input logic [CNT_W-1:0] cnt);
    return {3'b001, op, regIdx, 2'b00, cnt};
  endfunction

endpackage

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl
  import cfg_seq_pkg::*;
#(
  parameter int NOP_PAD = 2,
  parameter int RD_WAIT = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrReq,
  input  logic rdReq,
  output logic done,
  output ctrlT ctrl
);

  localparam int PRE      = 1 + NOP_PAD;
  localparam int HDR_I    = PRE;
  localparam int DATA_I   = PRE + 1;
  localparam int WR_TAIL  = PRE + 2 + NOP_PAD;
  localparam int TURN_I   = PRE + 1 + NOP_PAD;
  localparam int RD_TAIL  = TURN_I + 1 + RD_WAIT;
  localparam int CAP_I    = RD_TAIL - 1;
  localparam int WR_LEN   = WR_TAIL + 2 + NOP_PAD;
  localparam int RD_LEN   = RD_TAIL + 2 + NOP_PAD;
  localparam int STEP_W   = $clog2(RD_LEN + 1);

  localparam logic [STEP_W-1:0] HDR_S     = STEP_W'(HDR_I);
  localparam logic [STEP_W-1:0] DATA_S    = STEP_W'(DATA_I);
  localparam logic [STEP_W-1:0] TURN_S    = STEP_W'(TURN_I);
  localparam logic [STEP_W-1:0] CAP_S     = STEP_W'(CAP_I);
  localparam logic [STEP_W-1:0] WR_TAIL_S = STEP_W'(WR_TAIL);
  localparam logic [STEP_W-1:0] WR_DSY_S  = STEP_W'(WR_TAIL + 1);
  localparam logic [STEP_W-1:0] RD_TAIL_S = STEP_W'(RD_TAIL);
  localparam logic [STEP_W-1:0] RD_DSY_S  = STEP_W'(RD_TAIL + 1);
  localparam logic [STEP_W-1:0] WR_LAST_S = STEP_W'(WR_LEN - 1);
  localparam logic [STEP_W-1:0] RD_LAST_S = STEP_W'(RD_LEN - 1);

  typedef enum logic {ST_IDLE, ST_RUN} stateT;

  stateT             state;
  logic [STEP_W-1:0] step;
  logic              isRead;
  logic              doneQ;
  logic              accept;
  logic [STEP_W-1:0] lastStep;
  logic [STEP_W-1:0] tailStep;
  logic [STEP_W-1:0] dsyStep;

  assign accept   = (state == ST_IDLE) && !doneQ && (wrReq || rdReq);
  assign lastStep = isRead ? RD_LAST_S : WR_LAST_S;
  assign tailStep = isRead ? RD_TAIL_S : WR_TAIL_S;
  assign dsyStep  = isRead ? RD_DSY_S  : WR_DSY_S;
  assign done     = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      step   <= '0;
      isRead <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (accept) begin
        state  <= ST_RUN;
        step   <= '0;
        isRead <= !wrReq;   // write wins when both strobes are high
      end else if (state == ST_RUN) begin
        if (step == lastStep) begin
          state <= ST_IDLE;
          step  <= '0;
          doneQ <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrl.load    = accept;
    ctrl.capture = 1'b0;
    ctrl.rdOp    = isRead;
    ctrl.csN     = 1'b1;
    ctrl.rdWrN   = 1'b0;
    ctrl.sel     = SEL_NOP;
    if (state == ST_RUN) begin
      ctrl.csN = 1'b0;
      if (step == '0)                      ctrl.sel = SEL_SYNC;
      else if (step == HDR_S)              ctrl.sel = SEL_HDR;
      else if (!isRead && step == DATA_S)  ctrl.sel = SEL_DATA;
      else if (step == tailStep)           ctrl.sel = SEL_CMDHDR;
      else if (step == dsyStep)            ctrl.sel = SEL_DESYNC;
      if (isRead && step == TURN_S) begin
        ctrl.csN   = 1'b1;
        ctrl.rdWrN = 1'b1;
      end
      if (isRead && step > TURN_S && step < RD_TAIL_S) ctrl.rdWrN = 1'b1;
      ctrl.capture = isRead && (step == CAP_S);
    end
  end

endmodule

// File: rtl/cfg_seq_datapath.sv
module cfg_seq_datapath
  import cfg_seq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       wrData,
  input  logic [31:0]       portDout,
  output logic              portCsN,
  output logic              portRdWrN,
  output logic [31:0]       portDin,
  output logic [31:0]       rdData
);

  logic [REG_FIELD_W-1:0] addrQ;
  logic [31:0]            dataQ;
  logic [31:0]            capQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (ctrl.load) begin
      addrQ <= REG_FIELD_W'(regAddr);
      dataQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             capQ <= '0;
    else if (ctrl.capture) capQ <= portDout;
  end

  always_comb begin
    case (ctrl.sel)
      SEL_SYNC:   portDin = SYNC_WORD;
      SEL_HDR:    portDin = makeHeader(ctrl.rdOp ? OP_RD : OP_WR, addrQ, CNT_W'(1));
      SEL_DATA:   portDin = dataQ;
      SEL_CMDHDR: portDin = makeHeader(OP_WR, CMD_REG, CNT_W'(1));
      SEL_DESYNC: portDin = DESYNC_CMD;
      default:    portDin = NOP_WORD;
    endcase
  end

  assign portCsN   = ctrl.csN;
  assign portRdWrN = ctrl.rdWrN;
  assign rdData    = capQ;

endmodule

// File: rtl/cfg_cmd_sequencer.sv
module cfg_cmd_sequencer
  import cfg_seq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int NOP_PAD = 2,
  parameter int RD_WAIT = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       wrData,
  input  logic              wrReq,
  input  logic              rdReq,
  output logic              done,
  output logic [31:0]       rdData,
  output logic              portCsN,
  output logic              portRdWrN,
  output logic [31:0]       portDin,
  input  logic [31:0]       portDout
);

  ctrlT ctrlBus;

  cfg_seq_ctrl #(.NOP_PAD(NOP_PAD), .RD_WAIT(RD_WAIT)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .wrReq (wrReq),
    .rdReq (rdReq),
    .done  (done),
    .ctrl  (ctrlBus)
  );

  cfg_seq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrlBus),
    .regAddr   (regAddr),
    .wrData    (wrData),
    .portDout  (portDout),
    .portCsN   (portCsN),
    .portRdWrN (portRdWrN),
    .portDin   (portDin),
    .rdData    (rdData)
  );

endmodule

// File: rtl/cfg_seq_chk.sv
module cfg_seq_chk
  import cfg_seq_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        done,
  input logic [31:0] rdData,
  input logic        portCsN,
  input logic        portRdWrN,
  input logic [31:0] portDin
);

  // R1
  idle_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    portCsN |-> (portDin == NOP_WORD));

  // R2
  sync_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!portCsN && !portRdWrN && portDin == SYNC_WORD) |=> (!portCsN && portDin == NOP_WORD));

  // R4
  desync_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!portCsN && !portRdWrN && portDin == DESYNC_CMD) |=> (!portCsN && portDin == NOP_WORD));

  // R6
  turn_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(portRdWrN) |-> portCsN);

  // R6
  turn_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portCsN && portRdWrN) |=> (!portCsN && portRdWrN));

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> $past(portRdWrN && !portCsN));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (portCsN && !portRdWrN && portDin == NOP_WORD));

endmodule

bind cfg_cmd_sequencer cfg_seq_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .done      (done),
  .rdData    (rdData),
  .portCsN   (portCsN),
  .portRdWrN (portRdWrN),
  .portDin   (portDin)
);

// File: tb/sim_cfg_cmd_sequencer.sv
`timescale 1ns/1ps
module sim_cfg_cmd_sequencer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] wrData = '0;
  logic        wrReq = 1'b0;
  logic        rdReq = 1'b0;
  logic        done;
  logic [31:0] rdData;
  logic        portCsN;
  logic        portRdWrN;
  logic [31:0] portDin;
  logic [31:0] portDout = '0;

  int errors = 0;
  int checks = 0;
  logic [31:0] lastRd = '0;

  always #5 clk = ~clk;

  cfg_cmd_sequencer u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrData(wrData),
    .wrReq(wrReq), .rdReq(rdReq), .done(done), .rdData(rdData),
    .portCsN(portCsN), .portRdWrN(portRdWrN), .portDin(portDin),
    .portDout(portDout)
  );

  function automatic logic [31:0] hdr(logic [1:0] op, logic [4:0] a);
    return 32'h20000000 | ({30'd0, op} << 27) | ({27'd0, a} << 13) | 32'd1;
  endfunction

  // expected {csN, rdWrN, word} at position k of a sequence
  function automatic logic [33:0] expWord(bit rd, logic [4:0] a, logic [31:0] d, int k);
    logic [31:0] nop = 32'h20000000;
    if (k == 0) return {2'b00, 32'hAA995566};
    if (k < 3)  return {2'b00, nop};
    if (!rd) begin
      case (k)
        3:       return {2'b00, hdr(2'b10, a)};
        4:       return {2'b00, d};
        7:       return {2'b00, 32'h30008001};
        8:       return {2'b00, 32'h0000000D};
        default: return {2'b00, nop};
      endcase
    end
    case (k)
      3:          return {2'b00, hdr(2'b01, a)};
      6:          return {2'b11, nop};
      7, 8, 9, 10: return {2'b01, nop};
      11:         return {2'b00, 32'h30008001};
      12:         return {2'b00, 32'h0000000D};
      default:    return {2'b00, nop};
    endcase
  endfunction

  function automatic string reqOf(bit rd, int k);
    if (k < 3) return "R2";
    if (!rd) return (k < 7) ? "R3" : "R4";
    if (k < 6) return "R5";
    if (k < 11) return "R6";
    return "R4";
  endfunction

  task automatic chk(string req, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chkIdle(string req);
    chk(req, {portCsN, portRdWrN, portDin}, {2'b10, 32'h20000000});
  endtask

  task automatic runTxn(bit doWr, bit doRd, logic [4:0] a, logic [31:0] d);
    bit rd;
    int len;
    logic [31:0] capExp;
    @(negedge clk);
    regAddr = a; wrData = d; wrReq = doWr; rdReq = doRd;
    rd  = doRd && !doWr;   // R10: write wins
    len = rd ? 15 : 11;
    capExp = lastRd;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      chk(reqOf(rd, k), {portCsN, portRdWrN, portDin}, expWord(rd, a, d, k));
      chk("R8", {33'd0, done}, 34'd0);
      portDout = $urandom;
      if (rd && k == 10) capExp = portDout;
      if (k == 1) begin
        // R9: inputs change while busy, strobes stay asserted
        regAddr = 5'($urandom);
        wrData  = $urandom;
        rdReq   = 1'b1;
      end
    end
    @(negedge clk);
    chk("R8", {33'd0, done}, 34'd1);
    chkIdle("R8");
    chk("R7", {2'b00, rdData}, {2'b00, capExp});
    lastRd = capExp;
    @(negedge clk);
    chk("R9", {33'd0, done}, 34'd0);
    chkIdle("R9");
    wrReq = 1'b0; rdReq = 1'b0;
    @(negedge clk);
    chkIdle("R1");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chkIdle("R1");
    chk("R1", {1'b0, done, rdData}, 34'd0);
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1");

    runTxn(1'b1, 1'b0, 5'd4, 32'h0000000F);     // reload command
    runTxn(1'b0, 1'b1, 5'h16, 32'h0);           // boot status read
    runTxn(1'b1, 1'b1, 5'd5, 32'h12345678);     // R10 both strobes
    runTxn(1'b1, 1'b0, 5'd0, 32'hAA995566);     // data equal to sync
    runTxn(1'b1, 1'b0, 5'd31, 32'h0000000D);    // data equal to desync
    runTxn(1'b0, 1'b1, 5'd31, 32'h0);

    for (int i = 0; i < 60; i++) begin
      int gap;
      bit w;
      bit r;
      gap = $urandom_range(0, 3);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        chkIdle("R1");
      end
      w = 1'($urandom);
      r = w ? 1'($urandom) : 1'b1;
      runTxn(w, r, 5'($urandom), $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1ms;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule